// File: doc/BRIEF.md
# DDR3 Power-Up and Mode-Register Programming Sequencer

This block steps a DDR3 SDRAM through its initialization for a memory controller. A one-cycle start strobe, raised whenever software rewrites one of the controller's configuration registers, launches a pass. On the first pass after reset the block waits a power-up interval taken from the refresh-rate setting. It then writes the four mode registers in the order MR2, MR3, MR1, MR0 and ends with a long ZQ calibration. Each mode-register word is assembled from live configuration fields, and some of those fields are split across non-adjacent address bits.

Any later strobe reprograms the device. The pass begins with a precharge-all, skips the power-up wait and goes straight to the mode-register writes. While a pass runs, the block holds a busy flag and withholds grants from the controller's read/write request path. A strobe that arrives during a pass is remembered and served as soon as the current pass ends.

Top module: `ddr3_mrs_seq`

## Requirements
- R1: Out of reset the sequencer is idle. `seq_busy` is 0, the bus carries NOP ({cs_n,ras_n,cas_n,we_n}=0111) with bank and address 0, and `req_grant` follows `req_valid`.
- R2: Take edge 0 as the clock edge that samples the first `init_trig` after reset. `seq_busy` is 1 from the cycle after edge 0, no precharge is issued, and MR2 appears on the bus in the cycle after edge 16*`refresh_rate`+8.
- R3: Mode-register writes use MRS (0000) with bank 2, 3, 1, 0 for MR2, MR3, MR1, MR0, in that order, each T_MRD cycles after the previous one. The MR3 word is all zeros, and every MRS address has bits 15:13 clear.
- R4: MR2 address: bits 10:9 carry `cfg_dyn_odt`, bit 7 `cfg_srt`, bit 6 `cfg_asr`, bits 4:3 `cfg_cwl` and bits 2:0 `cfg_pasr`. All other bits are 0.
- R5: MR1 address: `cfg_term` bits 2, 1, 0 go to A9, A6, A2, `cfg_drive` bits 1, 0 go to A5, A1, and `cfg_dll_off` goes to A0. All other bits are 0.
- R6: MR0 address: `cfg_twr` on A11:A9, A8=1, `cfg_cas_lat` bits 3:1 on A6:A4 and bit 0 on A2. All other bits are 0.
- R7: T_MOD cycles after MR0, a ZQCL (0110, A10=1, bank 0) is issued. `seq_busy` drops T_ZQINIT cycles after the ZQCL edge.
- R8: `req_grant` equals `req_valid` while `seq_busy` is 0 and is 0 while `seq_busy` is 1.
- R9: A strobe after a completed pass starts a repeat pass. A precharge-all (0010, A10=1, bank 0) appears one cycle after the sampling edge, and MR2 follows T_RP cycles later, with no power-up wait.
- R10: A strobe during a pass does not disturb that pass's timing. `seq_busy` then stays 1 through the end of the pass, and the repeat pass's precharge-all appears one cycle after the edge at which `seq_busy` would have dropped.
- R11: Each command occupies the bus for exactly one cycle, and the bus carries NOP whenever no command is issued or `seq_busy` is 0. A fresh pass puts 5 commands on the bus and a repeat pass puts 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_trig | input | 1 | One-cycle start strobe for a pass |
| refresh_rate | input | RATE_W | Refresh interval in cycles (scales the power-up wait) |
| cfg_dyn_odt | input | 2 | Dynamic termination code (MR2) |
| cfg_srt | input | 1 | Extended self-refresh temperature range (MR2) |
| cfg_asr | input | 1 | Automatic self-refresh enable (MR2) |
| cfg_cwl | input | 2 | CAS write latency code (MR2) |
| cfg_pasr | input | 3 | Partial-array self-refresh code (MR2) |
| cfg_term | input | 3 | Nominal termination code (MR1) |
| cfg_drive | input | 2 | Output drive strength code (MR1) |
| cfg_dll_off | input | 1 | 1 disables the device DLL (MR1) |
| cfg_twr | input | 3 | Write recovery code (MR0) |
| cfg_cas_lat | input | 4 | CAS latency code (MR0) |
| req_valid | input | 1 | Controller read/write request |
| req_grant | output | 1 | Request granted |
| seq_busy | output | 1 | Initialization pass in progress |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus |

## Verification
The assertions assume that `init_trig` is a single-cycle pulse and that a busy rise always follows a sampled strobe. They also assume the configuration fields stay constant from the strobe until `seq_busy` falls, because the words are built from live inputs at issue time. The stimulus respects this. It changes configuration only while the block is idle, pulses the strobe for one cycle from the falling edge, and raises the mid-pass strobe only while `seq_busy` is high. Timing parameters are set to at least 2 so that the assertion requiring a NOP after every command is valid.

// File: rtl/ddr3_seq_pkg.sv
package ddr3_seq_pkg;

   // bus command encodings, ordered {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] BUS_NOP  = 4'b0111;
   localparam logic [3:0] BUS_MRS  = 4'b0000;
   localparam logic [3:0] BUS_PREA = 4'b0010;
   localparam logic [3:0] BUS_ZQCL = 4'b0110;

   // next command a running pass will issue; ST_END means only the final wait remains
   typedef enum logic [2:0] {
      ST_PRE,
      ST_MR2,
      ST_MR3,
      ST_MR1,
      ST_MR0,
      ST_ZQ,
      ST_END
   } step_e;

   typedef struct packed {
      logic [1:0] dyn_odt;
      logic       srt;
      logic       asr;
      logic [1:0] cwl;
      logic [2:0] pasr;
      logic [2:0] term;
      logic [1:0] drive;
      logic       dll_off;
      logic [2:0] twr;
      logic [3:0] cas_lat;
   } mr_fields_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr3_mr_pack.sv
module ddr3_mr_pack
   import ddr3_seq_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  mr_fields_t          fld,
   output logic [ADDR_W-1:0]   mr0_word,
   output logic [ADDR_W-1:0]   mr1_word,
   output logic [ADDR_W-1:0]   mr2_word,
   output logic [ADDR_W-1:0]   mr3_word
);

   localparam int WORD_W = 16;

   logic [WORD_W-1:0] w0, w1, w2, w3;

   always_comb begin
      w2 = '0;
      w2[10:9] = fld.dyn_odt;
      w2[7]    = fld.srt;
      w2[6]    = fld.asr;
      w2[4:3]  = fld.cwl;
      w2[2:0]  = fld.pasr;
   end

   always_comb begin
      w1 = '0;
      w1[9] = fld.term[2];
      w1[6] = fld.term[1];
      w1[2] = fld.term[0];
      w1[5] = fld.drive[1];
      w1[1] = fld.drive[0];
      w1[0] = fld.dll_off;
   end

   always_comb begin
      w0 = '0;
      w0[11:9] = fld.twr;
      w0[8]    = 1'b1;
      w0[6:4]  = fld.cas_lat[3:1];
      w0[2]    = fld.cas_lat[0];
   end

   assign w3 = '0;

   generate
      if (ADDR_W < WORD_W) begin : g_bad_width
         $error("ddr3_mr_pack: ADDR_W must be at least 16");
      end else if (ADDR_W == WORD_W) begin : g_exact
         assign mr0_word = w0;
         assign mr1_word = w1;
         assign mr2_word = w2;
         assign mr3_word = w3;
      end else begin : g_padded
         assign mr0_word = {{(ADDR_W-WORD_W){1'b0}}, w0};
         assign mr1_word = {{(ADDR_W-WORD_W){1'b0}}, w1};
         assign mr2_word = {{(ADDR_W-WORD_W){1'b0}}, w2};
         assign mr3_word = {{(ADDR_W-WORD_W){1'b0}}, w3};
      end
   endgenerate

endmodule

// File: rtl/ddr3_gap_timer.sv
module ddr3_gap_timer #(
   parameter int CNT_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   // loading N makes expire true at the N-th following edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ddr3_init_ctrl.sv
module ddr3_init_ctrl
   import ddr3_seq_pkg::*;
#(
   parameter int RATE_W        = 16,
   parameter int CNT_W         = 21,
   parameter int REF_INTERVALS = 16,
   parameter int PWRUP_EXTRA   = 8,
   parameter int T_RP          = 6,
   parameter int T_MRD         = 4,
   parameter int T_MOD         = 12,
   parameter int T_ZQINIT      = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [RATE_W-1:0] refresh_rate,
   input  logic              expire,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic              issue,
   output step_e             step,
   output logic              busy
);

   step_e            step_q;
   logic             busy_q;
   logic             pend_q;
   logic             inited_q;
   logic             start;
   logic             finish;
   logic             relaunch;
   logic [CNT_W-1:0] pwrup_cyc;
   logic [CNT_W-1:0] gap_cyc;

   function automatic step_e step_after(input step_e s);
      case (s)
         ST_PRE:  return ST_MR2;
         ST_MR2:  return ST_MR3;
         ST_MR3:  return ST_MR1;
         ST_MR1:  return ST_MR0;
         ST_MR0:  return ST_ZQ;
         default: return ST_END;
      endcase
   endfunction

   assign start    = trig & ~busy_q;
   assign issue    = busy_q & expire & (step_q != ST_END);
   assign finish   = busy_q & expire & (step_q == ST_END);
   assign relaunch = finish & (pend_q | trig);

   assign pwrup_cyc = CNT_W'(refresh_rate) * CNT_W'(REF_INTERVALS) + CNT_W'(PWRUP_EXTRA);

   always_comb begin
      case (step_q)
         ST_PRE:  gap_cyc = CNT_W'(T_RP);
         ST_MR0:  gap_cyc = CNT_W'(T_MOD);
         ST_ZQ:   gap_cyc = CNT_W'(T_ZQINIT);
         default: gap_cyc = CNT_W'(T_MRD);
      endcase
   end

   always_comb begin
      load     = start | issue | relaunch;
      load_val = gap_cyc;
      if (start && !inited_q) begin
         load_val = pwrup_cyc;
      end else if (start || relaunch) begin
         load_val = CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         step_q   <= ST_MR2;
         inited_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         step_q <= inited_q ? ST_PRE : ST_MR2;
      end else if (issue) begin
         step_q <= step_after(step_q);
      end else if (finish) begin
         inited_q <= 1'b1;
         if (relaunch) begin
            step_q <= ST_PRE;
         end else begin
            busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (finish) begin
         pend_q <= 1'b0;
      end else if (trig && busy_q) begin
         pend_q <= 1'b1;
      end
   end

   assign step = step_q;
   assign busy = busy_q;

   // a pass only begins on a sampled strobe
   assert_busy_from_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(trig));

   // a remembered strobe never lets busy fall
   assert_pending_holds_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> !$past(pend_q));

endmodule

// File: rtl/ddr3_mrs_seq.sv
module ddr3_mrs_seq
   import ddr3_seq_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int BA_W          = 3,
   parameter int RATE_W        = 16,
   parameter int REF_INTERVALS = 16,
   parameter int PWRUP_EXTRA   = 8,
   parameter int T_RP          = 6,
   parameter int T_MRD         = 4,
   parameter int T_MOD         = 12,
   parameter int T_ZQINIT      = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_trig,
   input  logic [RATE_W-1:0] refresh_rate,
   input  logic [1:0]        cfg_dyn_odt,
   input  logic              cfg_srt,
   input  logic              cfg_asr,
   input  logic [1:0]        cfg_cwl,
   input  logic [2:0]        cfg_pasr,
   input  logic [2:0]        cfg_term,
   input  logic [1:0]        cfg_drive,
   input  logic              cfg_dll_off,
   input  logic [2:0]        cfg_twr,
   input  logic [3:0]        cfg_cas_lat,
   input  logic              req_valid,
   output logic              req_grant,
   output logic              seq_busy,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [BA_W-1:0]   mem_ba,
   output logic [ADDR_W-1:0] mem_addr
);

   localparam int PWR_W = RATE_W + $clog2(REF_INTERVALS + 1) + 1;
   localparam int GAP_W = $clog2(imax(imax(T_RP, T_MRD), imax(T_MOD, T_ZQINIT)) + 1);
   localparam int CNT_W = imax(PWR_W, GAP_W);
   localparam int A10   = 10;

   generate
      if (BA_W < 2) begin : g_bad_ba
         $error("ddr3_mrs_seq: BA_W must be at least 2");
      end
      if (T_RP < 2 || T_MRD < 2 || T_MOD < 2 || T_ZQINIT < 2) begin : g_bad_gap
         $error("ddr3_mrs_seq: every command gap must be at least 2 cycles");
      end
      if (PWRUP_EXTRA < 1 || REF_INTERVALS < 1) begin : g_bad_pwrup
         $error("ddr3_mrs_seq: power-up wait terms must be positive");
      end
   endgenerate

   mr_fields_t        fld;
   logic [ADDR_W-1:0] mr0_w, mr1_w, mr2_w, mr3_w;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_expire;
   logic              issue;
   step_e             step;
   logic              busy;

   logic [3:0]        bus_q,  bus_d;
   logic [BA_W-1:0]   ba_q,   ba_d;
   logic [ADDR_W-1:0] addr_q, addr_d;

   assign fld = '{dyn_odt: cfg_dyn_odt, srt: cfg_srt, asr: cfg_asr, cwl: cfg_cwl,
                  pasr: cfg_pasr, term: cfg_term, drive: cfg_drive,
                  dll_off: cfg_dll_off, twr: cfg_twr, cas_lat: cfg_cas_lat};

   ddr3_mr_pack #(.ADDR_W(ADDR_W)) u_pack (
      .fld      (fld),
      .mr0_word (mr0_w),
      .mr1_word (mr1_w),
      .mr2_word (mr2_w),
      .mr3_word (mr3_w)
   );

   ddr3_gap_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   ddr3_init_ctrl #(
      .RATE_W        (RATE_W),
      .CNT_W         (CNT_W),
      .REF_INTERVALS (REF_INTERVALS),
      .PWRUP_EXTRA   (PWRUP_EXTRA),
      .T_RP          (T_RP),
      .T_MRD         (T_MRD),
      .T_MOD         (T_MOD),
      .T_ZQINIT      (T_ZQINIT)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig         (init_trig),
      .refresh_rate (refresh_rate),
      .expire       (tmr_expire),
      .load         (tmr_load),
      .load_val     (tmr_val),
      .issue        (issue),
      .step         (step),
      .busy         (busy)
   );

   always_comb begin
      bus_d  = BUS_NOP;
      ba_d   = '0;
      addr_d = '0;
      if (issue) begin
         case (step)
            ST_PRE: begin
               bus_d       = BUS_PREA;
               addr_d[A10] = 1'b1;
            end
            ST_MR2: begin
               bus_d  = BUS_MRS;
               ba_d   = BA_W'(2);
               addr_d = mr2_w;
            end
            ST_MR3: begin
               bus_d  = BUS_MRS;
               ba_d   = BA_W'(3);
               addr_d = mr3_w;
            end
            ST_MR1: begin
               bus_d  = BUS_MRS;
               ba_d   = BA_W'(1);
               addr_d = mr1_w;
            end
            ST_MR0: begin
               bus_d  = BUS_MRS;
               ba_d   = BA_W'(0);
               addr_d = mr0_w;
            end
            ST_ZQ: begin
               bus_d       = BUS_ZQCL;
               addr_d[A10] = 1'b1;
            end
            default: begin
               bus_d = BUS_NOP;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_q  <= BUS_NOP;
         ba_q   <= '0;
         addr_q <= '0;
      end else begin
         bus_q  <= bus_d;
         ba_q   <= ba_d;
         addr_q <= addr_d;
      end
   end

   assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = bus_q;
   assign mem_ba    = ba_q;
   assign mem_addr  = addr_q;
   assign seq_busy  = busy;
   assign req_grant = req_valid & ~busy;

   assert_idle_nop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> (bus_q == BUS_NOP));

   assert_cmd_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_q != BUS_NOP) |=> (bus_q == BUS_NOP));

   assert_no_grant_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_q != BUS_NOP) |-> !req_grant);

   assert_mrs_bank_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_q == BUS_MRS) |-> ((ba_q < BA_W'(4)) && (addr_q[ADDR_W-1:13] == '0)));

endmodule

// File: tb/sim_ddr3_mrs_seq.sv
`timescale 1ns/1ps
module sim_ddr3_mrs_seq;

   localparam int P_RP  = 6;
   localparam int P_MRD = 4;
   localparam int P_MOD = 12;
   localparam int P_ZQ  = 64;

   typedef struct packed {
      logic        fresh;
      logic [7:0]  rate;
      logic [1:0]  odt;
      logic        srt;
      logic        asr;
      logic [1:0]  cwl;
      logic [2:0]  pasr;
      logic [2:0]  term;
      logic [1:0]  drive;
      logic        dll;
      logic [2:0]  twr;
      logic [3:0]  cl;
      logic [15:0] e2;
      logic [15:0] e1;
      logic [15:0] e0;
   } vec_t;

   // expected words worked out by hand from the bit maps in R4, R5 and R6
   localparam vec_t VECS [0:3] = '{
      '{1'b1, 8'd2, 2'b01, 1'b1, 1'b0, 2'b10, 3'b101, 3'b100, 2'b01, 1'b0, 3'b110, 4'b1010,
        16'h0295, 16'h0202, 16'h0D50},
      '{1'b0, 8'd5, 2'b10, 1'b0, 1'b1, 2'b01, 3'b010, 3'b011, 2'b10, 1'b1, 3'b011, 4'b0101,
        16'h044A, 16'h0065, 16'h0724},
      '{1'b1, 8'd0, 2'b11, 1'b1, 1'b1, 2'b11, 3'b111, 3'b111, 2'b11, 1'b1, 3'b111, 4'b1111,
        16'h06DF, 16'h0267, 16'h0F74},
      '{1'b0, 8'd3, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000, 3'b000, 2'b00, 1'b0, 3'b000, 4'b0000,
        16'h0000, 16'h0000, 16'h0100}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_trig = 1'b0;
   logic [15:0] refresh_rate = '0;
   logic [1:0]  cfg_dyn_odt = '0;
   logic        cfg_srt = 1'b0;
   logic        cfg_asr = 1'b0;
   logic [1:0]  cfg_cwl = '0;
   logic [2:0]  cfg_pasr = '0;
   logic [2:0]  cfg_term = '0;
   logic [1:0]  cfg_drive = '0;
   logic        cfg_dll_off = 1'b0;
   logic [2:0]  cfg_twr = '0;
   logic [3:0]  cfg_cas_lat = '0;
   logic        req_valid = 1'b0;
   logic        req_grant, seq_busy;
   logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
   logic [2:0]  mem_ba;
   logic [15:0] mem_addr;

   int checks = 0;
   int errors = 0;

   int t_pre, t_pre2, t2, t3, t1, t0, tz, tend, n_pre, n_cmd;
   logic [15:0] w2, w3, w1, w0;
   bit grant_bad;

   always #2 clk = ~clk;

   ddr3_mrs_seq #(
      .T_RP(P_RP), .T_MRD(P_MRD), .T_MOD(P_MOD), .T_ZQINIT(P_ZQ)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .init_trig(init_trig), .refresh_rate(refresh_rate),
      .cfg_dyn_odt(cfg_dyn_odt), .cfg_srt(cfg_srt), .cfg_asr(cfg_asr), .cfg_cwl(cfg_cwl),
      .cfg_pasr(cfg_pasr), .cfg_term(cfg_term), .cfg_drive(cfg_drive),
      .cfg_dll_off(cfg_dll_off), .cfg_twr(cfg_twr), .cfg_cas_lat(cfg_cas_lat),
      .req_valid(req_valid), .req_grant(req_grant), .seq_busy(seq_busy),
      .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
      .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic apply_cfg(input vec_t v);
      refresh_rate = 16'(v.rate);
      cfg_dyn_odt = v.odt; cfg_srt = v.srt; cfg_asr = v.asr; cfg_cwl = v.cwl;
      cfg_pasr = v.pasr; cfg_term = v.term; cfg_drive = v.drive; cfg_dll_off = v.dll;
      cfg_twr = v.twr; cfg_cas_lat = v.cl;
   endtask

   // edge 0 samples the strobe; index k means the bus as driven by edge k
   task automatic run_pass(input int retrig_k);
      t_pre = -1; t_pre2 = -1; t2 = -1; t3 = -1; t1 = -1; t0 = -1; tz = -1; tend = -1;
      n_pre = 0; n_cmd = 0; grant_bad = 0;
      w2 = '1; w3 = '1; w1 = '1; w0 = '1;
      @(negedge clk);
      init_trig = 1'b1;
      req_valid = 1'b1;
      @(negedge clk);
      init_trig = 1'b0;
      chk(seq_busy === 1'b1, "R2/R9 busy after strobe", int'(seq_busy), 1);
      for (int k = 1; k < 4000; k++) begin
         @(negedge clk);
         init_trig = (k == retrig_k);
         if (req_grant !== (req_valid & ~seq_busy)) grant_bad = 1;
         if (!seq_busy) begin
            tend = k;
            break;
         end
         if ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} != 4'b0111) n_cmd++;
         case ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n})
            4'b0010: if (mem_addr[10] && mem_ba == 3'd0) begin
               n_pre++;
               if (n_pre == 1) t_pre = k; else t_pre2 = k;
            end
            4'b0000: case (mem_ba)
               3'd2: if (t2 < 0) begin t2 = k; w2 = mem_addr; end
               3'd3: if (t3 < 0) begin t3 = k; w3 = mem_addr; end
               3'd1: if (t1 < 0) begin t1 = k; w1 = mem_addr; end
               3'd0: if (t0 < 0) begin t0 = k; w0 = mem_addr; end
               default: ;
            endcase
            4'b0110: if (tz < 0 && mem_addr[10] && mem_ba == 3'd0) tz = k;
            default: ;
         endcase
         if (n_pre == 2) break;
      end
      init_trig = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R1: idle state out of reset
      req_valid = 1'b1;
      @(negedge clk);
      chk(seq_busy === 1'b0, "R1 busy", int'(seq_busy), 0);
      chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} === 4'b0111, "R1 bus NOP",
          int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 7);
      chk(mem_ba === 3'd0 && mem_addr === 16'd0, "R1 bank/address", int'(mem_addr), 0);
      chk(req_grant === 1'b1, "R1/R8 grant follows request", int'(req_grant), 1);
      req_valid = 1'b0;
      @(negedge clk);
      chk(req_grant === 1'b0, "R1/R8 no request no grant", int'(req_grant), 0);

      for (int i = 0; i < 4; i++) begin
         vec_t v;
         int base;
         v = VECS[i];
         if (v.fresh) do_reset();
         apply_cfg(v);
         run_pass(-1);
         base = v.fresh ? (16 * int'(v.rate) + 8) : (1 + P_RP);
         if (v.fresh) begin
            chk(n_pre == 0, "R2 no precharge on first pass", n_pre, 0);
            chk(t2 == base, "R2 power-up wait to MR2", t2, base);
            chk(n_cmd == 5, "R11 fresh command count", n_cmd, 5);
         end else begin
            chk(t_pre == 1, "R9 precharge-all timing", t_pre, 1);
            chk(t2 == base, "R9 MR2 after precharge", t2, base);
            chk(n_cmd == 6, "R11 repeat command count", n_cmd, 6);
         end
         chk(t3 == t2 + P_MRD, "R3 MR3 spacing", t3, t2 + P_MRD);
         chk(t1 == t3 + P_MRD, "R3 MR1 spacing", t1, t3 + P_MRD);
         chk(t0 == t1 + P_MRD, "R3 MR0 spacing", t0, t1 + P_MRD);
         chk(w3 == 16'h0000, "R3 MR3 word", int'(w3), 0);
         chk(w2 == v.e2, "R4 MR2 word", int'(w2), int'(v.e2));
         chk(w1 == v.e1, "R5 MR1 word", int'(w1), int'(v.e1));
         chk(w0 == v.e0, "R6 MR0 word", int'(w0), int'(v.e0));
         chk(tz == t0 + P_MOD, "R7 ZQCL after MR0", tz, t0 + P_MOD);
         chk(tend == tz + P_ZQ, "R7 busy release", tend, tz + P_ZQ);
         chk(!grant_bad, "R8 grant gating during pass", int'(grant_bad), 0);
         @(negedge clk);
         chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} === 4'b0111, "R11 NOP after pass",
             int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 7);
      end

      // R10: strobe during a repeat pass is held and served right after it
      begin
         int fin;
         apply_cfg(VECS[1]);
         run_pass(3);
         fin = (1 + P_RP) + 3 * P_MRD + P_MOD + P_ZQ;
         chk(t2 == 1 + P_RP, "R10 current pass timing unchanged", t2, 1 + P_RP);
         chk(tend == -1, "R10 busy held through pass end", tend, -1);
         chk(t_pre2 == fin + 1, "R10 repeat precharge timing", t_pre2, fin + 1);
         for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (!seq_busy) break;
         end
         chk(seq_busy === 1'b0, "R10 second pass completes", int'(seq_busy), 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule